// File: doc/BRIEF.md
# Oversampled Serial Receiver with Character Queue

This block turns an asynchronous serial line into 8-bit characters. The line is first passed through a two-flop synchroniser. It is then looked at once per baud tick. A programmable divider makes one tick every `baud_div_i` clock cycles, and sixteen ticks make one bit period. A falling edge on an idle line starts a frame. Each bit of the frame is settled by a best-of-three vote over the samples around the middle of the bit. A start bit that the vote finds high is dropped as noise.

Each finished character goes into an eight-entry queue together with a flag that says whether its stop bit was bad. The queue is drained through a one-cycle pop strobe, and it reports its fill level and an empty flag. When a new character arrives while the queue is full, the queue throws away everything it holds, the new character included. It does not just drop the newest byte.

Top module: `uart_rx_top`

## Requirements
- R1: The idle line is high. A frame begins when the synchronised line is high at one baud tick and low at the next. Ticks come every `baud_div_i` clock cycles (a value of 0 acts as 1), and one bit spans 16 ticks.
- R2: The tick that sees the falling edge counts as sample 1. The start bit's level is the majority of samples 7, 8 and 9. If that majority is high, the frame is abandoned and nothing is stored.
- R3: Each of the 8 data bits and the stop bit is decided by the same majority of samples 7, 8 and 9 of its own bit period. Data bits arrive least significant bit first, and a character is written into the queue only in a cycle that carries a baud tick.
- R4: If the stop bit's majority is low, the character is still stored and its `rd_ferr_o` bit is 1. A high stop bit stores `rd_ferr_o` = 0.
- R5: After a frame ends, the receiver accepts the next frame without a gap of more than one stop bit.
- R6: The queue holds up to 8 characters and returns them in arrival order. `count_o` gives the number held and never exceeds 8. A write without a pop raises the count by one.
- R7: A write into a full queue, in a cycle with no pop, empties the whole queue (`count_o` = 0) and discards the new character as well.
- R8: A pop while the queue is not empty shows the oldest character on `rd_data_o`/`rd_ferr_o` from the next cycle on. `empty_o` is high exactly when `count_o` is 0.
- R9: A pop while the queue is empty leaves `rd_data_o`, `rd_ferr_o` and `count_o` unchanged.
- R10: After synchronous reset, `empty_o` = 1, `count_o` = 0, and `rd_data_o` = 0 and `rd_ferr_o` = 0.
- R11: Changing `baud_div_i` while the line is idle changes the bit rate the receiver expects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div_i | input | 12 | Clock cycles per baud tick (16 ticks per bit) |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| pop_i | input | 1 | Remove the oldest character from the queue |
| rd_data_o | output | 8 | Last character popped |
| rd_ferr_o | output | 1 | Framing-error flag of the last character popped |
| empty_o | output | 1 | Queue holds no characters |
| count_o | output | 4 | Number of characters held |

## Verification
The bench drives a short low pulse that ends before the centre of the start bit. A receiver that did not re-vote the start bit would store a bogus character, and the scoreboard would see it as unexpected. It overfills the queue by exactly one character and expects an empty queue afterwards. A design that dropped only the newest byte would keep a count of 8. It pops an empty queue and expects the previous character to remain on the outputs, which exposes a pointer that moves anyway. It also sends frames with a low stop bit, bit patterns with every bit at its extreme, and a second divisor value. These catch a wrong bit order, a missing error flag and a hard-wired rate.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int OSR    = 16;
    localparam int PH_W   = $clog2(OSR);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_baudgen.sv
module uart_rx_baudgen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
    assign tick_o = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt >= lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     rx_i,
    output logic     push_o,
    output rx_char_t char_o
);
    rx_state_e             state;
    logic [PH_W-1:0]       phase;
    logic [2:0]            bit_idx;
    logic [1:0]            early;
    logic                  last_rx;
    logic [CHAR_W-1:0]     shreg;
    logic                  vote;
    logic                  mid;
    logic                  bit_end;

    assign vote    = vote3(early[1], early[0], rx_i);
    assign mid     = tick_i && (phase == PH_W'(8));
    assign bit_end = tick_i && (phase == PH_W'(OSR - 1));

    assign push_o      = (state == RX_STOP) && mid;
    assign char_o.data = shreg;
    assign char_o.ferr = ~vote;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            phase   <= '0;
            bit_idx <= '0;
            early   <= '0;
            last_rx <= 1'b1;
            shreg   <= '0;
        end else if (tick_i) begin
            last_rx <= rx_i;
            phase   <= phase + 1'b1;
            if (phase == PH_W'(6) || phase == PH_W'(7)) begin
                early <= {early[0], rx_i};
            end
            unique case (state)
                RX_IDLE: begin
                    phase <= PH_W'(1);
                    if (last_rx && !rx_i) begin
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (mid && vote) begin
                        state <= RX_IDLE;
                    end else if (bit_end) begin
                        state   <= RX_DATA;
                        bit_idx <= '0;
                    end
                end
                RX_DATA: begin
                    if (mid) begin
                        shreg <= {vote, shreg[CHAR_W-1:1]};
                    end
                    if (bit_end) begin
                        if (bit_idx == 3'(CHAR_W - 1)) begin
                            state <= RX_STOP;
                        end
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (mid) begin
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  rx_char_t      wdata_i,
    input  logic          pop_i,
    output rx_char_t      rdata_o,
    output logic [CW-1:0] count_o
);
    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;
    logic            rd;
    logic            full;
    logic            flush;

    assign full  = (count_o == CW'(DEPTH));
    assign rd    = pop_i && (count_o != '0);
    assign flush = push_i && full && !rd;

    always_ff @(posedge clk) begin
        if (push_i && !flush) begin
            mem[wptr] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count_o <= '0;
            rdata_o <= '0;
        end else if (flush) begin
            wptr    <= '0;
            rptr    <= '0;
            count_o <= '0;
        end else begin
            if (push_i) begin
                wptr <= wptr + 1'b1;
            end
            if (rd) begin
                rdata_o <= mem[rptr];
                rptr    <= rptr + 1'b1;
            end
            count_o <= count_o + CW'(push_i) - CW'(rd);
        end
    end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  baud_div_i,
    input  logic              rx_i,
    input  logic              pop_i,
    output logic [CHAR_W-1:0] rd_data_o,
    output logic              rd_ferr_o,
    output logic              empty_o,
    output logic [CW-1:0]     count_o
);
    logic     tick_w;
    logic     rx_s;
    logic     push_w;
    rx_char_t char_w;
    rx_char_t head_w;

    uart_rx_baudgen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .div_i(baud_div_i), .tick_o(tick_w)
    );

    uart_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_i(rx_i), .q_o(rx_s)
    );

    uart_rx_frame u_frame (
        .clk(clk), .rst(rst), .tick_i(tick_w), .rx_i(rx_s),
        .push_o(push_w), .char_o(char_w)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(push_w), .wdata_i(char_w),
        .pop_i(pop_i), .rdata_o(head_w), .count_o(count_o)
    );

    assign rd_data_o = head_w.data;
    assign rd_ferr_o = head_w.ferr;
    assign empty_o   = (count_o == '0);
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          push,
    input logic          pop,
    input logic          empty,
    input logic [CW-1:0] count,
    input logic [7:0]    rd_data,
    input logic          rd_ferr
);
    AST_PUSH_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        push |-> tick);                                                  // R3

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));                                            // R6

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count < CW'(DEPTH)) |=> count == $past(count) + 1'b1); // R6

    AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count == CW'(DEPTH)) |=> count == '0);          // R7

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> ($stable(rd_data) && $stable(rd_ferr) && count == '0)); // R9
endmodule

bind uart_rx_top uart_rx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .tick(tick_w), .push(push_w), .pop(pop_i),
    .empty(empty_o), .count(count_o), .rd_data(rd_data_o), .rd_ferr(rd_ferr_o)
);

// File: tb/uart_rx_top_bench.sv
module uart_rx_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] baud_div_i = 12'd4;
    logic        rx_i = 1'b1;
    logic        pop_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        rd_ferr_o;
    logic        empty_o;
    logic [3:0]  count_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_top u_uart_rx_top (
        .clk(clk), .rst(rst), .baud_div_i(baud_div_i), .rx_i(rx_i), .pop_i(pop_i),
        .rd_data_o(rd_data_o), .rd_ferr_o(rd_ferr_o), .empty_o(empty_o), .count_o(count_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bits(input int nbits);
        repeat (nbits * 16 * int'(baud_div_i)) @(negedge clk);
    endtask

    // Driver: sends one frame and records the expected scoreboard item.
    task automatic send(input logic [7:0] b, input logic stop, input bit expect_it, input string req);
        if (expect_it) begin
            exp_q.push_back({~stop, b});
            tag_q.push_back(req);
        end
        rx_i = 1'b0;
        hold_bits(1);
        for (int i = 0; i < 8; i++) begin
            rx_i = b[i];
            hold_bits(1);
        end
        rx_i = stop;
        hold_bits(1);
        rx_i = 1'b1;
        if (!stop) hold_bits(1);
    endtask

    task automatic drain;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && empty_o) break;
        end
        check("R6 drain", 16'(exp_q.size()), 16'd0);
    endtask

    task automatic settle;
        repeat (200) @(negedge clk);
    endtask

    task automatic monitor;
        forever begin
            @(negedge clk);
            if (mon_en && !empty_o) begin
                pop_i = 1'b1;
                @(negedge clk);
                pop_i = 1'b0;
                if (exp_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R2 unexpected char actual=%0h expected=none", {rd_ferr_o, rd_data_o});
                end else begin
                    automatic string t = tag_q.pop_front();
                    check(t, 16'({rd_ferr_o, rd_data_o}), 16'(exp_q.pop_front()));
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        fork monitor(); join_none
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 empty", 16'(empty_o), 16'd1);
        check("R10 count", 16'(count_o), 16'd0);
        check("R10 data",  16'(rd_data_o), 16'd0);
        check("R10 ferr",  16'(rd_ferr_o), 16'd0);
        settle();

        mon_en = 1'b1;
        // R1 R3 R5 back-to-back frames, LSB first
        send(8'hA5, 1'b1, 1'b1, "R3 A5");
        send(8'h3C, 1'b1, 1'b1, "R3 3C");
        send(8'h00, 1'b1, 1'b1, "R1 00");
        send(8'hFF, 1'b1, 1'b1, "R5 FF");
        send(8'h81, 1'b1, 1'b1, "R3 81");
        drain();

        // R4 low stop bit still stored, flagged
        send(8'h5A, 1'b0, 1'b1, "R4 ferr");
        send(8'hC3, 1'b1, 1'b1, "R4 clean");
        drain();

        // R2 false start: low for 3 ticks only
        rx_i = 1'b0;
        repeat (3 * int'(baud_div_i)) @(negedge clk);
        rx_i = 1'b1;
        hold_bits(3);
        check("R2 false start count", 16'(count_o), 16'd0);

        // R11 other divisor
        baud_div_i = 12'd6;
        settle();
        send(8'h96, 1'b1, 1'b1, "R11 div6");
        drain();
        baud_div_i = 12'd4;
        settle();

        // R7 overflow flush
        mon_en = 1'b0;
        settle();
        for (int i = 0; i < 8; i++) send(8'h10 + 8'(i), 1'b1, 1'b0, "R6");
        settle();
        check("R6 full count", 16'(count_o), 16'd8);
        check("R8 not empty", 16'(empty_o), 16'd0);
        send(8'h99, 1'b1, 1'b0, "R7");
        settle();
        check("R7 flushed count", 16'(count_o), 16'd0);
        check("R7 flushed empty", 16'(empty_o), 16'd1);

        // R9 pop on empty holds outputs
        held = rd_data_o;
        check("R9 prior data", 16'(held), 16'h96);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
        @(negedge clk);
        check("R9 data held", 16'(rd_data_o), 16'(held));
        check("R9 count held", 16'(count_o), 16'd0);

        // R8 order after flush
        send(8'h21, 1'b1, 1'b1, "R8 first");
        send(8'h42, 1'b1, 1'b1, "R8 second");
        settle();
        check("R8 two held", 16'(count_o), 16'd2);
        mon_en = 1'b1;
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule